// File: doc/BRIEF.md
# NAND Command Sequencer with Two-Plane Program and Block Erase

This block is the device-side front end of a NAND-style flash command interface. A host drives one bus cycle at a time on an 8-bit bus. Each cycle is tagged as a command, an address or a data byte. The block decodes those cycles into two operations. The first is a two-plane page program: a first-plane load phase, a short intermediate busy, a second-plane load phase, and then one long program busy that writes both planes together. The second is a block erase that keeps only the block-select part of the row address. While an operation runs, an active-low ready/busy pin is held low for a parameterised number of clock cycles.

The memory array, the page buffer contents and the verify algorithm are modelled away. The pass/fail outcome of a program or erase is taken from the `verify_fail` input on the cycle the operation finishes. A status byte reports the ready bit in bit 6 and the fail bit in bit 0. After a status-read command, each read pulse returns that byte. The bus has no back-pressure: every tagged cycle is consumed on the clock edge where `cyc_valid` is high, so the host may issue one cycle per clock. A read pulse returns its byte exactly one cycle later. Cycles that the current state does not accept are dropped and leave no trace.

Top module: `nand_cmd_ctrl`

## Requirements
- R1: After reset, `rb_n` is 1, `rd_valid` is 0 and the status byte is 40h (ready, no fail).
- R2: After command 70h, each `rd_pulse` gives `rd_valid` high on the next cycle, with `rd_byte` = {0, ready, 00000, fail}: ready in bit 6, fail in bit 0. Any other accepted command ends status mode, after which read pulses give no `rd_valid`.
- R3: Cycle tags are `cyc_kind` 0 = command, 1 = address, 2 = data. A program address has two column cycles followed by three row cycles. Bit 7 of the third address cycle is the plane select bit. Command 80h, the address, data, then 11h with plane bit 0 drives `rb_n` low for exactly T_DBSY cycles, starting the cycle after 11h.
- R4: After that busy, command 81h, the address, data, then 10h with plane bit 1 drives `rb_n` low for exactly T_PROG cycles, starting the cycle after 10h.
- R5: A plane bit of 1 at 11h, or of 0 at 10h, aborts the sequence to idle and `rb_n` stays high. A later 81h/10h pair does not start programming.
- R6: During either load phase, command 85h followed by further column address cycles and data is accepted. It does not change the captured plane bit, and the following confirm still starts the operation.
- R7: Command 60h, exactly three row address cycles, then D0h drives `rb_n` low for T_ERASE cycles. `op_block` = {third[3:0], second[7:0], first[7]}. All other address bits are ignored. D0h with fewer than three address cycles aborts to idle.
- R8: While an erase is busy, every command other than 70h and FFh is ignored, and address and data cycles are ignored too. The erase ends at its normal time, the block address is unchanged, and the block returns to idle.
- R9: The fail bit takes the value of `verify_fail` on the last busy cycle of a program or erase. Starting a new program or erase clears it, and so does FFh. The fail bit does not say which plane failed.
- R10: Command FFh, accepted in any state, including busy, ends the current operation. `rb_n` is high on the next cycle and the status byte reads 40h.
- R11: Status bit 6 equals `rb_n` at the moment of each read pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_kind | input | 2 | 0 command, 1 address, 2 data, 3 ignored |
| cyc_byte | input | 8 | Bus byte of the cycle |
| rd_pulse | input | 1 | Read-enable pulse from the host |
| verify_fail | input | 1 | Injected outcome of the running program or erase |
| rb_n | output | 1 | Ready/busy, low while busy |
| rd_valid | output | 1 | `rd_byte` holds a returned status byte |
| rd_byte | output | 8 | Returned status byte |
| op_block | output | ROW_BITS-PG_BITS | Block address latched when an erase starts |

## Verification
The bench goes after the plane-select check at both confirms. A design that ignored the bit would start a busy on a wrong-plane sequence. It also issues random-data-input commands inside the load phases, where a design that let late address cycles overwrite the row would fail the plane check. During an erase it sends setup, address and unrelated commands. A decoder that honoured them would shift the busy length, corrupt the block address, or stay armed so that a lone D0h afterwards starts a second erase. Reset in mid-erase and status mode ending on a fresh command are checked too: a mistake in either shows as a missing ready, a stale fail bit or an unexpected read byte.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_DATA = 2'd2,
    K_NONE = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD1,
    S_DBSY,
    S_WAIT2,
    S_LOAD2,
    S_PBSY,
    S_EADR,
    S_EBSY
  } ctl_state_e;

  localparam logic [7:0] OP_PLANE0_SETUP = 8'h80;
  localparam logic [7:0] OP_PLANE1_SETUP = 8'h81;
  localparam logic [7:0] OP_COL_CHANGE   = 8'h85;
  localparam logic [7:0] OP_DUMMY_CONF   = 8'h11;
  localparam logic [7:0] OP_PROG_CONF    = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP  = 8'h60;
  localparam logic [7:0] OP_ERASE_CONF   = 8'hD0;
  localparam logic [7:0] OP_STATUS       = 8'h70;
  localparam logic [7:0] OP_ABORT        = 8'hFF;

endpackage

// File: rtl/nand_row_capture.sv
module nand_row_capture #(
  parameter int COL_CYC  = 2,
  parameter int ROW_CYC  = 3,
  parameter int ROW_BITS = 20,
  parameter int PG_BITS  = 7,
  localparam int KEEP_W  = ROW_BITS - PG_BITS,
  localparam int TOT_CYC = COL_CYC + ROW_CYC,
  localparam int CNT_W   = $clog2(TOT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              row_first_in,
  input  logic              we,
  input  logic [7:0]        din,
  output logic [KEEP_W-1:0] keep_bits,
  output logic              full
);

  logic [CNT_W-1:0] cnt;
  logic             row_first;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] pos;
  logic             in_row;

  assign lim    = row_first ? CNT_W'(ROW_CYC) : CNT_W'(TOT_CYC);
  assign full   = (cnt >= lim);
  assign pos    = row_first ? cnt : (cnt - CNT_W'(COL_CYC));
  assign in_row = row_first ? 1'b1 : (cnt >= CNT_W'(COL_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      row_first <= 1'b0;
    end else if (clr) begin
      cnt       <= '0;
      row_first <= row_first_in;
    end else if (we && !full) begin
      cnt <= cnt + 1'b1;
    end
  end

  // keep only the row bits the controller decodes
  for (genvar b = 0; b < KEEP_W; b++) begin : g_bit
    localparam int RB  = b + PG_BITS;
    localparam int CYC = RB / 8;
    localparam int BIT = RB % 8;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        keep_bits[b] <= 1'b0;
      else if (clr)
        keep_bits[b] <= 1'b0;
      else if (we && !full && in_row && (pos == CNT_W'(CYC)))
        keep_bits[b] <= din[BIT];
    end
  end

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             cancel,
  output logic             active,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign done = active && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (cancel) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= load;
    end else if (active) begin
      if (done) active <= 1'b0;
      else      cnt    <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/nand_status_unit.sv
module nand_status_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic       fail_clr,
  input  logic       fail_set,
  input  logic       fail_val,
  input  logic       stat_on,
  input  logic       stat_off,
  input  logic       rd_pulse,
  output logic       rd_valid,
  output logic [7:0] rd_byte
);

  logic fail_q;
  logic stat_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q    <= 1'b0;
      stat_mode <= 1'b0;
      rd_valid  <= 1'b0;
      rd_byte   <= 8'h00;
    end else begin
      if (fail_clr)      fail_q <= 1'b0;
      else if (fail_set) fail_q <= fail_val;

      if (stat_on)       stat_mode <= 1'b1;
      else if (stat_off) stat_mode <= 1'b0;

      rd_valid <= rd_pulse && stat_mode;
      if (rd_pulse && stat_mode)
        rd_byte <= {1'b0, ready, 5'b00000, fail_q};
    end
  end

endmodule

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl
  import nand_cmd_pkg::*;
#(
  parameter int T_DBSY   = 5,
  parameter int T_PROG   = 40,
  parameter int T_ERASE  = 64,
  parameter int COL_CYC  = 2,
  parameter int ROW_CYC  = 3,
  parameter int ROW_BITS = 20,
  parameter int PG_BITS  = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cyc_valid,
  input  logic [1:0]                  cyc_kind,
  input  logic [7:0]                  cyc_byte,
  input  logic                        rd_pulse,
  input  logic                        verify_fail,
  output logic                        rb_n,
  output logic                        rd_valid,
  output logic [7:0]                  rd_byte,
  output logic [ROW_BITS-PG_BITS-1:0] op_block
);

  localparam int BLK_W  = ROW_BITS - PG_BITS;
  localparam int T_MAX0 = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
  localparam int T_MAX  = (T_MAX0 > T_DBSY) ? T_MAX0 : T_DBSY;
  localparam int TCW    = $clog2(T_MAX + 1);

  ctl_state_e st_q, st_d;

  logic             is_cmd, is_addr;
  logic             busy_st;
  logic             cap_clr, cap_row_first, cap_full;
  logic [BLK_W-1:0] cap_bits;
  logic             plane_bit;
  logic             tmr_start, tmr_cancel, tmr_active, tmr_done;
  logic [TCW-1:0]   tmr_load;
  logic             fail_clr, fail_set;
  logic             stat_on, stat_off;
  logic             blk_latch;

  assign is_cmd    = cyc_valid && (cyc_kind == K_CMD);
  assign is_addr   = cyc_valid && (cyc_kind == K_ADDR);
  assign busy_st   = (st_q == S_DBSY) || (st_q == S_PBSY) || (st_q == S_EBSY);
  assign plane_bit = cap_bits[0];
  assign rb_n      = !busy_st;

  always_comb begin
    st_d          = st_q;
    cap_clr       = 1'b0;
    cap_row_first = 1'b0;
    tmr_start     = 1'b0;
    tmr_load      = '0;
    tmr_cancel    = 1'b0;
    fail_clr      = 1'b0;
    fail_set      = 1'b0;
    stat_on       = 1'b0;
    stat_off      = 1'b0;
    blk_latch     = 1'b0;

    if (is_cmd && cyc_byte == OP_ABORT) begin
      st_d       = S_IDLE;
      tmr_cancel = 1'b1;
      fail_clr   = 1'b1;
      stat_off   = 1'b1;
    end else begin
      if (is_cmd && cyc_byte == OP_STATUS)
        stat_on = 1'b1;

      if (busy_st) begin
        if (tmr_done) begin
          if (st_q == S_DBSY) begin
            st_d = S_WAIT2;
          end else begin
            st_d     = S_IDLE;
            fail_set = 1'b1;
          end
        end
      end else if (is_cmd && cyc_byte != OP_STATUS) begin
        stat_off = 1'b1;
        st_d     = S_IDLE;
        unique case (st_q)
          S_IDLE: begin
            if (cyc_byte == OP_PLANE0_SETUP) begin
              st_d    = S_LOAD1;
              cap_clr = 1'b1;
            end else if (cyc_byte == OP_ERASE_SETUP) begin
              st_d          = S_EADR;
              cap_clr       = 1'b1;
              cap_row_first = 1'b1;
            end
          end
          S_LOAD1: begin
            if (cyc_byte == OP_COL_CHANGE) begin
              st_d = S_LOAD1;
            end else if (cyc_byte == OP_DUMMY_CONF && cap_full && !plane_bit) begin
              st_d      = S_DBSY;
              tmr_start = 1'b1;
              tmr_load  = TCW'(T_DBSY);
            end
          end
          S_WAIT2: begin
            if (cyc_byte == OP_PLANE1_SETUP) begin
              st_d    = S_LOAD2;
              cap_clr = 1'b1;
            end
          end
          S_LOAD2: begin
            if (cyc_byte == OP_COL_CHANGE) begin
              st_d = S_LOAD2;
            end else if (cyc_byte == OP_PROG_CONF && cap_full && plane_bit) begin
              st_d      = S_PBSY;
              tmr_start = 1'b1;
              tmr_load  = TCW'(T_PROG);
              fail_clr  = 1'b1;
            end
          end
          S_EADR: begin
            if (cyc_byte == OP_ERASE_CONF && cap_full) begin
              st_d      = S_EBSY;
              tmr_start = 1'b1;
              tmr_load  = TCW'(T_ERASE);
              fail_clr  = 1'b1;
              blk_latch = 1'b1;
            end
          end
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      op_block <= '0;
    end else begin
      st_q <= st_d;
      if (blk_latch) op_block <= cap_bits;
    end
  end

  nand_row_capture #(
    .COL_CYC (COL_CYC),
    .ROW_CYC (ROW_CYC),
    .ROW_BITS(ROW_BITS),
    .PG_BITS (PG_BITS)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (cap_clr),
    .row_first_in(cap_row_first),
    .we          (is_addr && (st_q == S_LOAD1 || st_q == S_LOAD2 || st_q == S_EADR)),
    .din         (cyc_byte),
    .keep_bits   (cap_bits),
    .full        (cap_full)
  );

  nand_busy_timer #(
    .CNT_W(TCW)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .load  (tmr_load),
    .cancel(tmr_cancel),
    .active(tmr_active),
    .done  (tmr_done)
  );

  nand_status_unit u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (!busy_st),
    .fail_clr(fail_clr),
    .fail_set(fail_set),
    .fail_val(verify_fail),
    .stat_on (stat_on),
    .stat_off(stat_off),
    .rd_pulse(rd_pulse),
    .rd_valid(rd_valid),
    .rd_byte (rd_byte)
  );

  logic unused_ok;
  assign unused_ok = tmr_active;

endmodule

// File: rtl/nand_cmd_ctrl_chk.sv
module nand_cmd_ctrl_chk #(
  parameter int BLK_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_valid,
  input logic [1:0]       cyc_kind,
  input logic [7:0]       cyc_byte,
  input logic             rd_pulse,
  input logic             rb_n,
  input logic             rd_valid,
  input logic [7:0]       rd_byte,
  input logic [BLK_W-1:0] op_block
);

  // R2
  rd_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_pulse));

  // R11
  ready_bit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_byte[6] == $past(rb_n)));

  // R2
  reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_byte[7] == 1'b0 && rd_byte[5:1] == 5'b0));

  // R3
  busy_only_after_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_n) |-> ($past(cyc_valid) && $past(cyc_kind) == 2'd0 &&
                     ($past(cyc_byte) == 8'h11 || $past(cyc_byte) == 8'h10 ||
                      $past(cyc_byte) == 8'hD0)));

  // R10
  abort_gives_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind == 2'd0 && cyc_byte == 8'hFF) |=> rb_n);

  // R8
  block_stable_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_n && $past(!rb_n)) |-> $stable(op_block));

endmodule

bind nand_cmd_ctrl nand_cmd_ctrl_chk #(.BLK_W(ROW_BITS - PG_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_valid(cyc_valid),
  .cyc_kind (cyc_kind),
  .cyc_byte (cyc_byte),
  .rd_pulse (rd_pulse),
  .rb_n     (rb_n),
  .rd_valid (rd_valid),
  .rd_byte  (rd_byte),
  .op_block (op_block)
);

// File: tb/nand_cmd_ctrl_bench.sv
module nand_cmd_ctrl_bench;

  localparam int T_DBSY  = 5;
  localparam int T_PROG  = 40;
  localparam int T_ERASE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [1:0]  cyc_kind = 2'd3;
  logic [7:0]  cyc_byte = 8'h00;
  logic        rd_pulse = 1'b0;
  logic        verify_fail = 1'b0;
  logic        rb_n;
  logic        rd_valid;
  logic [7:0]  rd_byte;
  logic [12:0] op_block;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  nand_cmd_ctrl u_nand_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
    .cyc_byte(cyc_byte), .rd_pulse(rd_pulse), .verify_fail(verify_fail),
    .rb_n(rb_n), .rd_valid(rd_valid), .rd_byte(rd_byte), .op_block(op_block)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] k, input logic [7:0] b);
    cyc_valid = 1'b1; cyc_kind = k; cyc_byte = b;
    @(negedge clk);
    cyc_valid = 1'b0; cyc_kind = 2'd3;
  endtask

  task automatic cmd(input logic [7:0] b);  bus(2'd0, b); endtask
  task automatic adr(input logic [7:0] b);  bus(2'd1, b); endtask
  task automatic dat(input logic [7:0] b);  bus(2'd2, b); endtask

  // driver: pushes the expected status byte, then pulses read
  task automatic rd(input logic [7:0] exp);
    expq.push_back(exp);
    rd_pulse = 1'b1;
    @(negedge clk);
    rd_pulse = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rb_n && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic load(input logic [7:0] setup, input logic pl, input bit rnd);
    cmd(setup);
    adr(8'h12); adr(8'h03);
    adr({pl, 7'h2A}); adr(8'h5C); adr(8'h01);
    for (int i = 0; i < 4; i++) dat(8'(i * 17));
    if (rnd) begin
      cmd(8'h85);
      adr(8'h40); adr(8'h00);
      dat(8'hEE); dat(8'h77);
      adr({~pl, 7'h00});
    end
  endtask

  // monitor: pops and compares each returned byte
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2 unexpected read", rd_byte, 0);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(rd_byte == e, "R2/R9/R11 status byte", rd_byte, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rb_n == 1'b1, "R1 rb_n", rb_n, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmd(8'h70); rd(8'h40);

    // R3 R4 R6 two-plane program with random data input, pass
    load(8'h80, 1'b0, 1'b1);
    cmd(8'h11);
    wait_ready(n);
    chk(n == T_DBSY, "R3 dummy busy length", n, T_DBSY);
    load(8'h81, 1'b1, 1'b1);
    cmd(8'h10);
    wait_ready(n);
    chk(n == T_PROG, "R4 R6 program busy length", n, T_PROG);
    cmd(8'h70); rd(8'h40);

    // R9 R11 program fail, status sampled while busy
    verify_fail = 1'b1;
    load(8'h80, 1'b0, 1'b0); cmd(8'h11); wait_ready(n);
    load(8'h81, 1'b1, 1'b0); cmd(8'h10);
    cmd(8'h70); rd(8'h00);
    wait_ready(n);
    chk(n == T_PROG - 2, "R4 busy length with status read", n, T_PROG - 2);
    rd(8'h41);
    verify_fail = 1'b0;

    // R10 reset clears fail
    cmd(8'hFF);
    cmd(8'h70); rd(8'h40);

    // R5 first-plane mismatch
    load(8'h80, 1'b1, 1'b0); cmd(8'h11);
    chk(rb_n == 1'b1, "R5 first plane mismatch", rb_n, 1);
    load(8'h81, 1'b1, 1'b0); cmd(8'h10);
    chk(rb_n == 1'b1, "R5 no program after abort", rb_n, 1);
    // R5 second-plane mismatch
    load(8'h80, 1'b0, 1'b0); cmd(8'h11); wait_ready(n);
    load(8'h81, 1'b0, 1'b0); cmd(8'h10);
    chk(rb_n == 1'b1, "R5 second plane mismatch", rb_n, 1);

    // R7 R8 erase with ignored traffic
    cmd(8'h60); adr(8'h83); adr(8'hA5); adr(8'hF3); cmd(8'hD0);
    chk(op_block == 13'h74B, "R7 erase block", op_block, 13'h74B);
    cmd(8'h80); cmd(8'h60); adr(8'h00); cmd(8'h70); rd(8'h00);
    wait_ready(n);
    chk(n + 5 == T_ERASE, "R8 erase length", n + 5, T_ERASE);
    chk(op_block == 13'h74B, "R8 block unchanged", op_block, 13'h74B);
    rd(8'h40);
    cmd(8'hD0);
    chk(rb_n == 1'b1, "R8 back in idle", rb_n, 1);

    // R7 short address aborts
    cmd(8'h60); adr(8'h00); adr(8'h11); cmd(8'hD0);
    chk(rb_n == 1'b1, "R7 short address", rb_n, 1);

    // R9 erase fail, then R10 abort mid-erase
    verify_fail = 1'b1;
    cmd(8'h60); adr(8'h00); adr(8'h01); adr(8'h00); cmd(8'hD0);
    wait_ready(n);
    chk(n == T_ERASE, "R7 erase length", n, T_ERASE);
    cmd(8'h70); rd(8'h41);
    cmd(8'h60); adr(8'h80); adr(8'h00); adr(8'h00); cmd(8'hD0);
    chk(rb_n == 1'b0, "R7 erase busy", rb_n, 0);
    repeat (3) @(negedge clk);
    cmd(8'hFF);
    chk(rb_n == 1'b1, "R10 abort mid-erase", rb_n, 1);
    verify_fail = 1'b0;
    repeat (T_ERASE) @(negedge clk);
    cmd(8'h70); rd(8'h40);

    // R2 status mode ends on a new command
    cmd(8'h00);
    rd_pulse = 1'b1; @(negedge clk); rd_pulse = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R2 status mode ended", rd_valid, 0);

    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R2 all reads returned", expq.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule